// File: doc/BRIEF.md
# Rank Word Decoder

This block turns one fetched memory word of a succinct bit-vector index into a rank value. A rank value is the number of ones up to and including a given position. Each word covers one block of the bit vector. Its upper field is a running header, the number of ones in every bit before the block. Its lower field is the block's raw bits. Alongside the word, the caller supplies the position of the query inside the block.

The decoder keeps only the body bits from bit 0 up to that position. It counts the ones that remain and adds the header. The work is spread over a three-stage pipeline, so a new query can enter on every clock. The body is cut into fixed-width lanes that are counted in parallel, and the lane counts are summed in the last stage. Memory fetch and address generation stay with the caller.

Top module: `rank_word_decoder`

## Requirements
- R1: The header is the top HDR_W bits of `in_word` (bits WORD_W-1 down to BODY_W). The body is the low BODY_W = WORD_W-HDR_W bits, with bit 0 the first position of the block.
- R2: For a query with offset k < BODY_W, `out_rank` equals the header plus the number of ones in body bits 0 through k inclusive.
- R3: An offset greater than or equal to BODY_W counts the whole body, so the result is the header plus the ones in all BODY_W body bits.
- R4: A query accepted with `in_valid` high on a rising edge produces `out_valid` high for one cycle after the third rising edge from it. `out_valid` is never high without such a query.
- R5: Queries may arrive on consecutive cycles with no gap. Each result depends only on its own word and offset.
- R6: Body bits above the offset have no effect on the result.
- R7: While reset (`rst_n` low) is applied, `out_valid` is 0 and `out_rank` is 0.
- R8: In cycles with `out_valid` low, `out_rank` keeps the last result, or 0 if there has been none since reset.
- R9: `out_rank` is HDR_W+1 bits wide and does not wrap, even for the maximum header with a full body of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Query present this cycle |
| in_word | input | WORD_W | Fetched word: header over body |
| in_offset | input | $clog2(BODY_W)+1 | Position of the query within the block |
| out_valid | output | 1 | Result present this cycle |
| out_rank | output | HDR_W+1 | Header plus masked ones count |

## Verification
The bench builds the decoder with a 128-bit word, a 16-bit header and 24-bit lanes. This gives a 112-bit body spread over five lanes, and the last lane is only partly filled. With these values the bench reaches the zero-padded tail of a lane, offsets beyond the body that must clamp, and a header of all ones summed with a full body. A behavioural queue model follows every cycle, including idle ones, so it covers both the fixed latency and the hold of the last result.

// File: rtl/rwd_pkg.sv
package rwd_pkg;

    // Number of lanes needed to cover a body of the given width.
    function automatic int lanes_for(input int body_w, input int lane_w);
        return (body_w + lane_w - 1) / lane_w;
    endfunction

    // Width needed to hold a count from 0 up to n.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rwd_mask_stage.sv
// Stage 1: keep body bits 0..offset, pad up to the lane grid, and register.
module rwd_mask_stage #(
    parameter int BODY_W = 112,
    parameter int HDR_W  = 16,
    parameter int OFF_W  = 8,
    parameter int PAD_W  = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [HDR_W-1:0]  in_hdr,
    input  logic [BODY_W-1:0] in_body,
    input  logic [OFF_W-1:0]  in_offset,
    output logic              s1_valid,
    output logic [HDR_W-1:0]  s1_hdr,
    output logic [PAD_W-1:0]  s1_bits
);

    logic [PAD_W-1:0] kept;

    // An offset at or past the body end keeps every live bit (clamp).
    for (genvar g = 0; g < PAD_W; g++) begin : g_bit
        if (g < BODY_W) begin : g_live
            assign kept[g] = in_body[g] & (OFF_W'(g) <= in_offset);
        end else begin : g_pad
            assign kept[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hdr   <= '0;
            s1_bits  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_hdr  <= in_hdr;
                s1_bits <= kept;
            end
        end
    end

endmodule

// File: rtl/rwd_lane_count.sv
// Combinational ones count over one lane.
module rwd_lane_count #(
    parameter int LANE_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic [LANE_W-1:0] bits,
    output logic [CNT_W-1:0]  count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < LANE_W; i++) begin
            count = count + CNT_W'(bits[i]);
        end
    end

endmodule

// File: rtl/rwd_count_stage.sv
// Stage 2: count every lane in parallel and register the partial counts.
module rwd_count_stage #(
    parameter int NUM_LANES = 7,
    parameter int LANE_W    = 16,
    parameter int CNT_W     = 5,
    parameter int HDR_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s1_valid,
    input  logic [HDR_W-1:0]           s1_hdr,
    input  logic [NUM_LANES*LANE_W-1:0] s1_bits,
    output logic                       s2_valid,
    output logic [HDR_W-1:0]           s2_hdr,
    output logic [NUM_LANES*CNT_W-1:0] s2_cnts
);

    logic [NUM_LANES*CNT_W-1:0] lane_cnts;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        rwd_lane_count #(
            .LANE_W(LANE_W),
            .CNT_W (CNT_W)
        ) u_cnt (
            .bits (s1_bits[l*LANE_W +: LANE_W]),
            .count(lane_cnts[l*CNT_W +: CNT_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_hdr   <= '0;
            s2_cnts  <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_hdr  <= s1_hdr;
                s2_cnts <= lane_cnts;
            end
        end
    end

endmodule

// File: rtl/rwd_sum_stage.sv
// Stage 3: add the lane counts to the header; the result holds between queries.
module rwd_sum_stage #(
    parameter int NUM_LANES = 7,
    parameter int CNT_W     = 5,
    parameter int HDR_W     = 16,
    parameter int RANK_W    = 17
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s2_valid,
    input  logic [HDR_W-1:0]           s2_hdr,
    input  logic [NUM_LANES*CNT_W-1:0] s2_cnts,
    output logic                       out_valid,
    output logic [RANK_W-1:0]          out_rank
);

    logic [RANK_W-1:0] total;

    always_comb begin
        total = RANK_W'(s2_hdr);
        for (int l = 0; l < NUM_LANES; l++) begin
            total = total + RANK_W'(s2_cnts[l*CNT_W +: CNT_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rank  <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                out_rank <= total;
            end
        end
    end

endmodule

// File: rtl/rank_word_decoder.sv
module rank_word_decoder #(
    parameter int WORD_W = 128,
    parameter int HDR_W  = 16,
    parameter int LANE_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [WORD_W-1:0]                      in_word,
    input  logic [$clog2(WORD_W-HDR_W):0]          in_offset,
    output logic                                   out_valid,
    output logic [HDR_W:0]                         out_rank
);

    localparam int BODY_W    = WORD_W - HDR_W;
    localparam int OFF_W     = $clog2(BODY_W) + 1;
    localparam int NUM_LANES = rwd_pkg::lanes_for(BODY_W, LANE_W);
    localparam int PAD_W     = NUM_LANES * LANE_W;
    localparam int CNT_W     = rwd_pkg::count_width(LANE_W);
    localparam int RANK_W    = HDR_W + 1;

    logic                       s1_valid;
    logic [HDR_W-1:0]           s1_hdr;
    logic [PAD_W-1:0]           s1_bits;
    logic                       s2_valid;
    logic [HDR_W-1:0]           s2_hdr;
    logic [NUM_LANES*CNT_W-1:0] s2_cnts;

    rwd_mask_stage #(
        .BODY_W(BODY_W),
        .HDR_W (HDR_W),
        .OFF_W (OFF_W),
        .PAD_W (PAD_W)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_hdr   (in_word[WORD_W-1 -: HDR_W]),
        .in_body  (in_word[BODY_W-1:0]),
        .in_offset(in_offset),
        .s1_valid (s1_valid),
        .s1_hdr   (s1_hdr),
        .s1_bits  (s1_bits)
    );

    rwd_count_stage #(
        .NUM_LANES(NUM_LANES),
        .LANE_W   (LANE_W),
        .CNT_W    (CNT_W),
        .HDR_W    (HDR_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .s1_valid(s1_valid),
        .s1_hdr  (s1_hdr),
        .s1_bits (s1_bits),
        .s2_valid(s2_valid),
        .s2_hdr  (s2_hdr),
        .s2_cnts (s2_cnts)
    );

    rwd_sum_stage #(
        .NUM_LANES(NUM_LANES),
        .CNT_W    (CNT_W),
        .HDR_W    (HDR_W),
        .RANK_W   (RANK_W)
    ) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .s2_valid (s2_valid),
        .s2_hdr   (s2_hdr),
        .s2_cnts  (s2_cnts),
        .out_valid(out_valid),
        .out_rank (out_rank)
    );

endmodule

// File: rtl/rwd_checker.sv
module rwd_checker #(
    parameter int WORD_W = 128,
    parameter int HDR_W  = 16,
    parameter int LANE_W = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [WORD_W-1:0]             in_word,
    input logic [$clog2(WORD_W-HDR_W):0] in_offset,
    input logic                          out_valid,
    input logic [HDR_W:0]                out_rank
);

    localparam int BODY_W = WORD_W - HDR_W;
    localparam int OFF_W  = $clog2(BODY_W) + 1;

    logic [HDR_W:0]    hdr_ext;
    logic              body_full;
    logic              off_clamped;

    assign hdr_ext     = {1'b0, in_word[WORD_W-1 -: HDR_W]};
    assign body_full   = &in_word[BODY_W-1:0];
    assign off_clamped = (in_offset >= OFF_W'(BODY_W));

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid); // R4

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3)); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_rank)); // R8

    AST_AT_LEAST_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_rank >= $past(hdr_ext, 3)); // R2

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_rank <= $past(hdr_ext, 3) + (HDR_W+1)'(BODY_W)); // R9

    AST_CLAMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(off_clamped, 3) && $past(body_full, 3))
        |-> out_rank == $past(hdr_ext, 3) + (HDR_W+1)'(BODY_W)); // R3

endmodule

bind rank_word_decoder rwd_checker #(
    .WORD_W(WORD_W),
    .HDR_W (HDR_W),
    .LANE_W(LANE_W)
) u_chk (.*);

// File: tb/sim_rank_word_decoder.sv
module sim_rank_word_decoder;

    localparam int WORD_W = 128;
    localparam int HDR_W  = 16;
    localparam int LANE_W = 24;
    localparam int BODY_W = WORD_W - HDR_W;
    localparam int OFF_W  = $clog2(BODY_W) + 1;

    typedef struct {
        bit    v;
        int    rank;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [WORD_W-1:0] in_word = '0;
    logic [OFF_W-1:0]  in_offset = '0;
    logic              out_valid;
    logic [HDR_W:0]    out_rank;

    int   n_checks = 0;
    int   n_fails = 0;
    int   last_rank = 0;
    bit   done = 1'b0;
    exp_t pipe_q[$];

    always #2.5 clk = ~clk;

    rank_word_decoder #(
        .WORD_W(WORD_W),
        .HDR_W (HDR_W),
        .LANE_W(LANE_W)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_word  (in_word),
        .in_offset(in_offset),
        .out_valid(out_valid),
        .out_rank (out_rank)
    );

    function automatic int model_rank(input logic [WORD_W-1:0] w, input int off);
        int r = int'(w[WORD_W-1 -: HDR_W]);
        for (int i = 0; i < BODY_W; i++) begin
            if (i <= off && w[i]) r++;
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] rand_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic compare();
        exp_t e;
        if (pipe_q.size() < 3) return;
        e = pipe_q.pop_front();
        if (e.v) last_rank = e.rank;
        n_checks++;
        if (out_valid !== e.v || int'(out_rank) != last_rank) begin
            n_fails++;
            $display("FAIL %s: valid=%0b rank=%0d expected valid=%0b rank=%0d",
                     e.tag, out_valid, out_rank, e.v, last_rank);
        end
    endtask

    task automatic step(input bit v, input logic [WORD_W-1:0] w, input int off,
                        input string tag);
        exp_t e;
        @(negedge clk);
        compare();
        in_valid  = v;
        in_word   = w;
        in_offset = OFF_W'(off);
        e.v    = v;
        e.rank = v ? model_rank(w, off) : 0;
        e.tag  = tag;
        pipe_q.push_back(e);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [WORD_W-1:0] w;
        exp_t idle;
        repeat (3) @(negedge clk);
        // R7: state while reset is held
        n_checks++;
        if (out_valid !== 1'b0 || out_rank !== '0) begin
            n_fails++;
            $display("FAIL R7: valid=%0b rank=%0d expected valid=0 rank=0", out_valid, out_rank);
        end
        rst_n = 1'b1;
        idle.v = 1'b0; idle.rank = 0; idle.tag = "R8";
        repeat (3) pipe_q.push_back(idle);

        // R2: inclusive count over a fixed alternating body
        w = {16'd5, {(BODY_W/2){2'b10}}};
        for (int k = 0; k < 24; k++) step(1'b1, w, k, "R2");
        step(1'b1, w, BODY_W - 1, "R2");

        // R1: header alone lands in the result when the counted body is zero
        for (int k = 0; k < 6; k++)
            step(1'b1, {HDR_W'(16'h1 << (k * 3)), {BODY_W{1'b0}}}, k * 20, "R1");

        // R6: bits above the offset vary, expected result stays fixed
        for (int k = 0; k < 10; k++) begin
            w = rand_word();
            w[WORD_W-1 -: HDR_W] = 16'd300;
            w[10:0] = 11'h5A5;
            step(1'b1, w, 10, "R6");
        end

        // R3: offsets at and past the body end count the full body
        for (int k = BODY_W - 1; k < (1 << OFF_W); k += 7)
            step(1'b1, {16'd77, {BODY_W{1'b1}}}, k, "R3");
        step(1'b1, {16'd9, rand_word() >> HDR_W}, (1 << OFF_W) - 1, "R3");

        // R9: largest header plus a full body of ones
        step(1'b1, {WORD_W{1'b1}}, BODY_W, "R9");
        step(1'b1, {WORD_W{1'b1}}, 0, "R9");

        // R4 and R8: isolated queries separated by idle cycles
        for (int k = 0; k < 6; k++) begin
            step(1'b1, rand_word(), k * 19, "R4");
            for (int j = 0; j < 4; j++) step(1'b0, rand_word(), 0, "R8");
        end

        // R5: back-to-back random stream
        for (int k = 0; k < 300; k++)
            step(1'b1, rand_word(), int'($urandom % (1 << OFF_W)), "R5");

        for (int k = 0; k < 5; k++) step(1'b0, '0, 0, "R8");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule